// File: doc/BRIEF.md
# Per-core programmable timer

This block is a timer that sits beside one processor core and raises an interrupt event on a schedule that software programs. It runs in one of three modes picked by two bits in its control register. In one-shot mode a prescaled down-counter counts from a loaded value to zero, raises one interrupt and stops. In periodic mode the same counter reloads its starting value each time it expires, so it produces a steady train of interrupts. In deadline mode the counter is idle and a 64-bit compare instead watches an externally supplied timestamp, raising one interrupt when the timestamp reaches the programmed deadline.

Software reaches the block through a simple word-wide register port. Writes take effect on the clock edge where the write strobe is sampled. Reads are combinational from the address. Five registers are provided: control (vector, mask, mode), clock divide select, start count, live count (read-only) and deadline. Every interrupt comes out as a single-cycle pulse, and the vector held in the control register at the time of the event is presented beside it. Delivering the interrupt to the core and generating the timestamp are left to neighbouring logic.

Top module: `core_local_timer`

## Requirements
- R1: After reset every register reads 0, the interrupt pulse is low and no interrupt occurs without a register write.
- R2: With control bits 18 and 17 both clear (one-shot), writing start count N to address 2 with divide select 0 raises exactly one interrupt pulse N cycles after the write edge; afterwards the live count (address 3) holds at 0 and no further pulse occurs.
- R3: With control bit 17 set and bit 18 clear (periodic), the counter reloads the start count when it expires, and interrupts recur every N times 2^d cycles.
- R4: The 3-bit divide select d at address 1 slows the counter by 2^d (d = 0 to 7 gives divide by 1 to 128). Writing the start count restarts the prescaler, so the first interrupt comes N times 2^d cycles after the write.
- R5: Writing a start count of 0 stops the counter at once: the live count reads 0 and no interrupt follows.
- R6: With control bit 18 set (deadline), an interrupt pulse is raised on the clock edge after the timestamp input is greater than or equal to the deadline (address 4). This includes a deadline that is already in the past when written. Each written deadline fires at most once.
- R7: Writing a deadline of 0 disarms deadline mode, and no interrupt follows, however large the timestamp becomes.
- R8: Control bit 16 (mask) suppresses the interrupt pulse but does not stop counting or reloading.
- R9: The vector output equals control bits 7:0 in the cycle where the interrupt pulse is high.
- R10: In deadline mode the down-counter does not count: a loaded start count stays unchanged in the live count.
- R11: Control reads back bits 18, 17, 16 and 7:0 as written and returns zero in the other bits. The live count reads the current counter value while the counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 divide, 2 start count, 3 live count, 4 deadline |
| reg_wdata | input | DATA_W (64) | Write data |
| reg_rdata | output | DATA_W (64) | Read data for reg_addr, combinational |
| ts_i | input | TS_W (64) | External timestamp |
| irq_pulse_o | output | 1 | Single-cycle interrupt event |
| irq_vector_o | output | 8 | Vector of the latest event |

## Verification
The hardest case to reach from the ports is the masked periodic reload. Nothing is visible on the interrupt output, so the bench reads the live count in the exact cycle after the expiry edge and expects the start value rather than zero. It then reads the count again two cycles later to show that counting continued. The deadline that is already in the past when written needs similar care: the timestamp is raised first, the deadline is written afterwards, and the pulse is expected on the very next edge. The bench also confirms that the pulse does not repeat while the timestamp keeps climbing.

// File: rtl/ltmr_pkg.sv
`timescale 1ns/1ps
package ltmr_pkg;

    localparam int ADDR_W        = 3;
    localparam int VEC_W         = 8;
    localparam int CTRL_MASK_BIT = 16;
    localparam int CTRL_PER_BIT  = 17;
    localparam int CTRL_DL_BIT   = 18;
    localparam int CTRL_W        = CTRL_DL_BIT + 1;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL     = 3'd0,
        ADDR_DIV      = 3'd1,
        ADDR_INIT     = 3'd2,
        ADDR_CUR      = 3'd3,
        ADDR_DEADLINE = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic             dl_mode;
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } ctrl_t;

endpackage

// File: rtl/ltmr_prescaler.sv
`timescale 1ns/1ps
module ltmr_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int PS_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [PS_W-1:0] cnt;
    } ps_state_t;

    ps_state_t       st_d, st_q;
    logic [PS_W-1:0] limit;

    always_comb begin
        for (int i = 0; i < PS_W; i++) begin
            limit[i] = (i < int'(div_sel));
        end
        st_d = st_q;
        tick = (st_q.cnt == limit) && !restart;
        if (restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ltmr_downcount.sv
`timescale 1ns/1ps
module ltmr_downcount #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             enable,
    input  logic             periodic,
    output logic [CNT_W-1:0] cur_count,
    output logic [CNT_W-1:0] init_count,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] init;
        logic [CNT_W-1:0] cur;
    } dc_state_t;

    dc_state_t st_d, st_q;
    logic      step;

    always_comb begin
        st_d   = st_q;
        step   = enable && tick && !load && (st_q.cur != '0);
        expire = step && (st_q.cur == CNT_W'(1));
        if (load) begin
            st_d.init = load_val;
            st_d.cur  = load_val;
        end else if (expire) begin
            st_d.cur = periodic ? st_q.init : '0;
        end else if (step) begin
            st_d.cur = st_q.cur - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_count  = st_q.cur;
    assign init_count = st_q.init;
endmodule

// File: rtl/ltmr_deadline.sv
`timescale 1ns/1ps
module ltmr_deadline #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [TS_W-1:0] wr_val,
    input  logic            enable,
    input  logic [TS_W-1:0] ts,
    output logic [TS_W-1:0] deadline,
    output logic            fire
);
    typedef struct packed {
        logic [TS_W-1:0] target;
        logic            armed;
    } dl_state_t;

    dl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = enable && st_q.armed && !wr && (ts >= st_q.target);
        if (wr) begin
            st_d.target = wr_val;
            st_d.armed  = (wr_val != '0);
        end else if (fire) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign deadline = st_q.target;
endmodule

// File: rtl/core_local_timer.sv
`timescale 1ns/1ps
module core_local_timer
    import ltmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TS_W   = 64,
    parameter int DIV_W  = 3,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [TS_W-1:0]   ts_i,
    output logic              irq_pulse_o,
    output logic [VEC_W-1:0]  irq_vector_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DIV_W-1:0]  div;
        logic              irq;
        logic [VEC_W-1:0]  vec;
    } top_state_t;

    top_state_t st_d, st_q;

    logic             ctrl_wr, div_wr, init_wr, dl_wr;
    logic             ps_tick, cnt_expire, dl_fire;
    logic             mode_deadline, mode_periodic, irq_mask;
    logic [CNT_W-1:0] cur_count, init_count;
    logic [TS_W-1:0]  deadline_val;
    logic [CTRL_W-1:0] ctrl_word;

    assign ctrl_wr = reg_we && (reg_addr == ADDR_CTRL);
    assign div_wr  = reg_we && (reg_addr == ADDR_DIV);
    assign init_wr = reg_we && (reg_addr == ADDR_INIT);
    assign dl_wr   = reg_we && (reg_addr == ADDR_DEADLINE);

    assign mode_deadline = st_q.ctrl.dl_mode;
    assign mode_periodic = st_q.ctrl.periodic && !st_q.ctrl.dl_mode;
    assign irq_mask      = st_q.ctrl.mask;

    ltmr_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (init_wr || div_wr),
        .div_sel (st_q.div),
        .tick    (ps_tick)
    );

    ltmr_downcount #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (init_wr),
        .load_val   (reg_wdata[CNT_W-1:0]),
        .tick       (ps_tick),
        .enable     (!mode_deadline),
        .periodic   (mode_periodic),
        .cur_count  (cur_count),
        .init_count (init_count),
        .expire     (cnt_expire)
    );

    ltmr_deadline #(.TS_W(TS_W)) u_dline (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (dl_wr),
        .wr_val   (reg_wdata[TS_W-1:0]),
        .enable   (mode_deadline),
        .ts       (ts_i),
        .deadline (deadline_val),
        .fire     (dl_fire)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ctrl.dl_mode  = reg_wdata[CTRL_DL_BIT];
            st_d.ctrl.periodic = reg_wdata[CTRL_PER_BIT];
            st_d.ctrl.mask     = reg_wdata[CTRL_MASK_BIT];
            st_d.ctrl.vector   = reg_wdata[VEC_W-1:0];
        end
        if (div_wr) begin
            st_d.div = reg_wdata[DIV_W-1:0];
        end
        st_d.irq = (cnt_expire || dl_fire) && !st_q.ctrl.mask;
        if (st_d.irq) begin
            st_d.vec = st_q.ctrl.vector;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_DL_BIT]   = st_q.ctrl.dl_mode;
        ctrl_word[CTRL_PER_BIT]  = st_q.ctrl.periodic;
        ctrl_word[CTRL_MASK_BIT] = st_q.ctrl.mask;
        ctrl_word[VEC_W-1:0]     = st_q.ctrl.vector;
        case (reg_addr)
            ADDR_CTRL:     reg_rdata = DATA_W'(ctrl_word);
            ADDR_DIV:      reg_rdata = DATA_W'(st_q.div);
            ADDR_INIT:     reg_rdata = DATA_W'(init_count);
            ADDR_CUR:      reg_rdata = DATA_W'(cur_count);
            ADDR_DEADLINE: reg_rdata = DATA_W'(deadline_val);
            default:       reg_rdata = '0;
        endcase
    end

    assign irq_pulse_o  = st_q.irq;
    assign irq_vector_o = st_q.vec;
endmodule

// File: rtl/ltmr_checker.sv
`timescale 1ns/1ps
module ltmr_checker #(
    parameter int CNT_W = 32,
    parameter int TS_W  = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_wr,
    input logic [CNT_W-1:0] wr_cnt,
    input logic             mode_deadline,
    input logic             mode_periodic,
    input logic             irq_mask,
    input logic             ps_tick,
    input logic [CNT_W-1:0] cur_count,
    input logic [CNT_W-1:0] init_count,
    input logic             dl_fire,
    input logic [TS_W-1:0]  ts_i,
    input logic [TS_W-1:0]  deadline_val,
    input logic             irq_pulse_o
);
    assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_deadline && !mode_periodic && cur_count == '0 && !init_wr) |=> (cur_count == '0));

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_periodic && ps_tick && cur_count == CNT_W'(1) && !init_wr) |=> (cur_count == init_count));

    assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (init_wr && wr_cnt == '0) |=> (cur_count == '0));

    assert_reach_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dl_fire |-> (ts_i >= deadline_val));

    assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dl_fire |-> (deadline_val != '0));

    assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse_o |-> !$past(irq_mask));

    assert_idle_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_deadline && !init_wr) |=> $stable(cur_count));
endmodule

bind core_local_timer ltmr_checker #(.CNT_W(CNT_W), .TS_W(TS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_wr       (init_wr),
    .wr_cnt        (reg_wdata[CNT_W-1:0]),
    .mode_deadline (mode_deadline),
    .mode_periodic (mode_periodic),
    .irq_mask      (irq_mask),
    .ps_tick       (ps_tick),
    .cur_count     (cur_count),
    .init_count    (init_count),
    .dl_fire       (dl_fire),
    .ts_i          (ts_i),
    .deadline_val  (deadline_val),
    .irq_pulse_o   (irq_pulse_o)
);

// File: tb/core_local_timer_tb.sv
`timescale 1ns/1ps
module core_local_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [63:0] ts = '0;
    logic        irq;
    logic [7:0]  vec;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    localparam logic [63:0] PER = 64'h2_0000;
    localparam logic [63:0] DLM = 64'h4_0000;
    localparam logic [63:0] MSK = 64'h1_0000;

    always #10 clk = ~clk;

    core_local_timer u_dut (
        .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .ts_i (ts),
        .irq_pulse_o (irq), .irq_vector_o (vec)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // cycles from the current point until the next pulse (0 = none within limit)
    task automatic wait_irq(input int limit, output int cyc);
        cyc = 0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk); #1;
            if (irq) begin cyc = i; break; end
        end
    endtask

    task automatic count_pulses(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            if (irq) n++;
        end
    endtask

    task automatic t_reset;
        logic [63:0] v;
        int n;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk(v == 0, "R1 reset register", v, 0);
        end
        chk(irq == 0, "R1 reset irq", 64'(irq), 0);
        count_pulses(20, n);
        chk(n == 0, "R1 idle no irq", 64'(n), 0);
    endtask

    task automatic t_oneshot;
        int c, n;
        logic [63:0] v;
        wr(3'd1, 0);
        wr(3'd0, 64'h5A);
        wr(3'd2, 5);
        wait_irq(50, c);
        chk(c == 5, "R2 one-shot delay", 64'(c), 5);
        chk(vec == 8'h5A, "R9 vector", 64'(vec), 64'h5A);
        @(posedge clk); #1;
        chk(irq == 0, "R9 single-cycle pulse", 64'(irq), 0);
        count_pulses(20, n);
        chk(n == 0, "R2 no second pulse", 64'(n), 0);
        rd(3'd3, v);
        chk(v == 0, "R2 count holds zero", v, 0);
    endtask

    task automatic t_divide(input int d, input int n0);
        int c;
        wr(3'd0, 64'h11);
        wr(3'd1, 64'(d));
        wr(3'd2, 64'(n0));
        wait_irq(5000, c);
        chk(c == (n0 << d), "R4 divided delay", 64'(c), 64'(n0 << d));
        wr(3'd1, 0);
    endtask

    task automatic t_periodic;
        int c;
        logic [63:0] v;
        wr(3'd1, 1);
        wr(3'd0, PER | 64'h33);
        wr(3'd2, 4);
        @(posedge clk); #1;
        @(posedge clk); #1;
        rd(3'd3, v);
        chk(v == 3, "R11 live count running", v, 3);
        wait_irq(100, c);
        chk(c == 6, "R3 first period", 64'(c), 6);
        chk(vec == 8'h33, "R9 periodic vector", 64'(vec), 64'h33);
        wait_irq(100, c);
        chk(c == 8, "R3 second period", 64'(c), 8);
        wait_irq(100, c);
        chk(c == 8, "R3 third period", 64'(c), 8);
        wr(3'd2, 0);
        wr(3'd1, 0);
    endtask

    task automatic t_stop;
        int n;
        logic [63:0] v;
        wr(3'd0, PER | 64'h44);
        wr(3'd2, 10);
        repeat (3) @(posedge clk);
        wr(3'd2, 0);
        rd(3'd3, v);
        chk(v == 0, "R5 count cleared", v, 0);
        count_pulses(40, n);
        chk(n == 0, "R5 halted no irq", 64'(n), 0);
    endtask

    task automatic t_mask;
        int n, c;
        logic [63:0] v;
        wr(3'd0, PER | MSK | 64'h66);
        rd(3'd0, v);
        chk(v == (PER | MSK | 64'h66), "R11 control readback", v, PER | MSK | 64'h66);
        wr(3'd2, 4);
        count_pulses(4, n);
        chk(n == 0, "R8 masked no irq", 64'(n), 0);
        rd(3'd3, v);
        chk(v == 4, "R8 reload while masked", v, 4);
        repeat (2) @(posedge clk);
        #1;
        rd(3'd3, v);
        chk(v == 2, "R8 keeps counting", v, 2);
        wr(3'd0, PER | 64'h66);
        wait_irq(10, c);
        chk(c >= 1 && c <= 4, "R8 unmasked irq returns", 64'(c), 4);
        chk(vec == 8'h66, "R9 vector after unmask", 64'(vec), 64'h66);
        wr(3'd2, 0);
    endtask

    task automatic t_deadline;
        int n, c;
        logic [63:0] v;
        wr(3'd0, DLM | 64'h77);
        ts = 64'd500;
        wr(3'd4, 64'd1000);
        rd(3'd4, v);
        chk(v == 1000, "R11 deadline readback", v, 1000);
        count_pulses(5, n);
        chk(n == 0, "R6 before deadline", 64'(n), 0);
        @(negedge clk);
        ts = 64'd1000;
        @(posedge clk); #1;
        chk(irq == 1, "R6 fires at deadline", 64'(irq), 1);
        chk(vec == 8'h77, "R9 deadline vector", 64'(vec), 64'h77);
        @(negedge clk);
        ts = 64'd5000;
        count_pulses(10, n);
        chk(n == 0, "R6 fires only once", 64'(n), 0);
        wr(3'd4, 64'd100);
        @(posedge clk); #1;
        chk(irq == 1, "R6 past deadline fires", 64'(irq), 1);
        wr(3'd4, 64'd0);
        @(negedge clk);
        ts = 64'hFFFF_FFFF_FFFF_FFFF;
        count_pulses(10, n);
        chk(n == 0, "R7 zero disarms", 64'(n), 0);
        ts = 64'd0;
    endtask

    task automatic t_dl_idle;
        int n;
        logic [63:0] v;
        wr(3'd0, DLM | 64'h01);
        wr(3'd2, 3);
        count_pulses(20, n);
        chk(n == 0, "R10 no count irq", 64'(n), 0);
        rd(3'd3, v);
        chk(v == 3, "R10 count frozen", v, 3);
        wr(3'd2, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_oneshot();
        t_divide(1, 3);
        t_divide(3, 2);
        t_divide(7, 3);
        t_periodic();
        t_stop();
        t_mask();
        t_deadline();
        t_dl_idle();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule